// File: doc/BRIEF.md
# Colour-Sequential Multichannel LED PWM

This block drives the brightness lines of an RGB LED display whose colours are multiplexed in time. A sequencer steps through three fixed colour slots (red, then green, then blue). A 3-bit one-hot bus enables the common electrode of the colour that is lit. Within each slot, every channel produces a pulse-width-modulated output. Its width comes from an 8-bit duty value, and all channels restart together on the slot boundary. The PWM period is 256 steps, and each slot holds a whole number of periods. A clock-enable prescaler sets the step rate from the system clock frequency, the slot length and the number of periods per slot.

Each channel holds a separate duty value for each of the three colours. A controller loads these values through a simple write port. A channel picks up the duty value for a colour only at the boundary that starts that colour's slot. A write made while a slot is running therefore never disturbs the pulse train on screen. With the default parameters (200 MHz clock, 3000 us slots, 4 periods per slot), one full colour cycle takes just under 9 ms.

Top module: `led_colour_pwm`

## Requirements
- R1: After reset, every `pwm_out` line is low, `colour_en` is 3'b001 (red), and every stored duty value is zero. The first red slot after reset therefore stays dark.
- R2: Within a slot, `pwm_out[i]` is high exactly while the 8-bit step counter is below the duty value that channel latched at the slot start.
- R3: The step counter advances once every STEP_DIV clocks. A PWM period is 256 steps, and a slot is PERIODS periods long.
- R4: `colour_en` is always one-hot, with bit 0 for red, bit 1 for green and bit 2 for blue. It moves red to green to blue and back to red.
- R5: `colour_en` changes on the same clock edge that the step counter returns to zero. Channels with a non-zero duty go high in that same cycle.
- R6: A channel whose latched duty is 0 never goes high.
- R7: A channel whose latched duty is 255 is high for 255 of every 256 steps.
- R8: A written duty value reaches the output only at the next boundary that starts the slot of that colour. A write during a slot leaves the current slot's output unchanged.
- R9: A write with `wr_colour` = 3 or with `wr_ch` >= NUM_CH changes no stored duty value. The write port codes colours as 0 red, 1 green, 2 blue.
- R10: Each channel keeps three independent duty values, one per colour. A write changes only the value selected by `wr_ch` and `wr_colour`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Duty write strobe |
| wr_ch | input | CH_W | Channel index of the write |
| wr_colour | input | 2 | Colour of the write: 0 red, 1 green, 2 blue |
| wr_duty | input | 8 | Duty value to store |
| pwm_out | output | NUM_CH | One PWM line per channel |
| colour_en | output | 3 | One-hot enable of the lit colour |

## Verification
All outputs come straight from registers, so the colour enable and the PWM lines move on the clock edge of a prescaler step. When a step ends a slot, the slot change lands on that same edge. A write is stored one edge after its strobe, but it appears on the outputs only at the next boundary of its colour, which can be thousands of cycles later. The bench keeps a per-edge model of its own and compares both outputs on every falling edge. It also checks the edges next to the boundaries and next to a duty crossing, and it totals the high time of each channel per slot, so every expected value is tied to the exact edge on which it is due.

// File: rtl/ledpwm_pkg.sv
package ledpwm_pkg;

    typedef enum logic [2:0] {
        COL_RED = 3'b001,
        COL_GRN = 3'b010,
        COL_BLU = 3'b100
    } colour_e;

    localparam int STEPS_PER_PERIOD = 256;

    typedef logic [7:0] duty_t;

    function automatic colour_e next_colour(colour_e c);
        case (c)
            COL_RED: next_colour = COL_GRN;
            COL_GRN: next_colour = COL_BLU;
            default: next_colour = COL_RED;
        endcase
    endfunction

    function automatic logic [1:0] colour_idx(colour_e c);
        case (c)
            COL_GRN: colour_idx = 2'd1;
            COL_BLU: colour_idx = 2'd2;
            default: colour_idx = 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/ledpwm_prescale.sv
module ledpwm_prescale #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic step_en
);
    generate
        if (DIV <= 1) begin : g_direct
            assign step_en = 1'b1;
        end else begin : g_count
            localparam int W = $clog2(DIV);
            logic [W-1:0] div_cnt;
            assign step_en = (div_cnt == W'(DIV - 1));
            always_ff @(posedge clk) begin
                if (rst)          div_cnt <= '0;
                else if (step_en) div_cnt <= '0;
                else              div_cnt <= div_cnt + 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/ledpwm_sequencer.sv
module ledpwm_sequencer
    import ledpwm_pkg::*;
#(
    parameter int PERIODS = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    step_en,
    output duty_t   cnt,
    output colour_e colour,
    output logic    load,
    output colour_e load_colour
);
    localparam int PER_W = (PERIODS > 1) ? $clog2(PERIODS) : 1;

    logic [PER_W-1:0] period;
    logic             period_end;
    logic             last_period;

    assign period_end  = step_en && (cnt == 8'hFF);
    assign last_period = (period == PER_W'(PERIODS - 1));
    assign load        = period_end && last_period;
    assign load_colour = next_colour(colour);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            period <= '0;
            colour <= COL_RED;
        end else if (step_en) begin
            cnt <= cnt + 1'b1;
            if (period_end) begin
                period <= last_period ? '0 : period + 1'b1;
                if (last_period) colour <= load_colour;
            end
        end
    end

    p_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        $countones(colour) == 1);

    p_order_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(colour) |-> colour == next_colour($past(colour)));

    p_align_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(colour) |-> (cnt == 8'd0 && period == '0));

    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(cnt));
endmodule

// File: rtl/ledpwm_bank.sv
module ledpwm_bank
    import ledpwm_pkg::*;
#(
    parameter int NUM_CH = 24,
    parameter int CH_W   = 5
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [CH_W-1:0]             wr_ch,
    input  logic [1:0]                  wr_colour,
    input  duty_t                       wr_duty,
    output logic [NUM_CH-1:0][2:0][7:0] duties
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        for (genvar c = 0; c < 3; c++) begin : g_col
            always_ff @(posedge clk) begin
                if (rst)
                    duties[i][c] <= '0;
                else if (wr_en && wr_ch == CH_W'(i) && wr_colour == 2'(c))
                    duties[i][c] <= wr_duty;
            end
        end
    end

    p_ignore_bad_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_colour == 2'd3) |=> $stable(duties));
endmodule

// File: rtl/ledpwm_channel.sv
module ledpwm_channel
    import ledpwm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  duty_t load_duty,
    input  duty_t cnt,
    output logic  pwm
);
    duty_t active;

    always_ff @(posedge clk) begin
        if (rst)       active <= '0;
        else if (load) active <= load_duty;
    end

    assign pwm = (cnt < active);

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(active));

    p_dark_r6: assert property (@(posedge clk) disable iff (rst)
        (active == 8'd0) |-> !pwm);
endmodule

// File: rtl/led_colour_pwm.sv
module led_colour_pwm
    import ledpwm_pkg::*;
#(
    parameter int NUM_CH  = 24,
    parameter int CLK_HZ  = 200_000_000,
    parameter int SLOT_US = 3000,
    parameter int PERIODS = 4,
    parameter int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [1:0]        wr_colour,
    input  logic [7:0]        wr_duty,
    output logic [NUM_CH-1:0] pwm_out,
    output logic [2:0]        colour_en
);
    localparam int SLOT_CYC = (CLK_HZ / 1_000_000) * SLOT_US;
    localparam int RAW_DIV  = SLOT_CYC / (STEPS_PER_PERIOD * PERIODS);
    localparam int STEP_DIV = (RAW_DIV < 1) ? 1 : RAW_DIV;

    logic                        step_en;
    duty_t                       cnt;
    colour_e                     colour;
    logic                        load;
    colour_e                     load_colour;
    logic [NUM_CH-1:0][2:0][7:0] duties;
    logic [1:0]                  load_sel;

    ledpwm_prescale #(.DIV(STEP_DIV)) u_pre (
        .clk(clk), .rst(rst), .step_en(step_en));

    ledpwm_sequencer #(.PERIODS(PERIODS)) u_seq (
        .clk(clk), .rst(rst), .step_en(step_en), .cnt(cnt),
        .colour(colour), .load(load), .load_colour(load_colour));

    ledpwm_bank #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ch(wr_ch),
        .wr_colour(wr_colour), .wr_duty(wr_duty), .duties(duties));

    assign load_sel = colour_idx(load_colour);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        ledpwm_channel u_ch (
            .clk(clk), .rst(rst), .load(load),
            .load_duty(duties[i][load_sel]), .cnt(cnt), .pwm(pwm_out[i]));
    end

    assign colour_en = colour;
endmodule

// File: tb/tb_led_colour_pwm.sv
module tb_led_colour_pwm;
    localparam int NCH    = 6;
    localparam int CW     = 3;
    localparam int STEP   = 4;
    localparam int SLOT   = 2048;
    localparam int NSLOTS = 7;

    logic           clk = 0;
    logic           rst = 1;
    logic           wr_en = 0;
    logic [CW-1:0]  wr_ch = '0;
    logic [1:0]     wr_colour = '0;
    logic [7:0]     wr_duty = '0;
    logic [NCH-1:0] pwm_out;
    logic [2:0]     colour_en;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit running = 0;
    int m_bank [NCH][3];
    int m_act  [NCH];
    int hist   [NSLOTS][NCH];

    led_colour_pwm #(.NUM_CH(NCH), .CLK_HZ(2_000_000), .SLOT_US(1024),
                     .PERIODS(2)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ch(wr_ch),
        .wr_colour(wr_colour), .wr_duty(wr_duty),
        .pwm_out(pwm_out), .colour_en(colour_en));

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    // reference model, one update per rising edge
    always @(posedge clk) begin
        if (rst) begin
            cyc = 0;
            foreach (m_act[i]) m_act[i] = 0;
            foreach (m_bank[i, c]) m_bank[i][c] = 0;
        end else begin
            cyc = cyc + 1;
            if (cyc % SLOT == 0)
                for (int i = 0; i < NCH; i++) m_act[i] = m_bank[i][(cyc / SLOT) % 3];
            if (wr_en && wr_colour != 2'd3 && int'(wr_ch) < NCH)
                m_bank[wr_ch][wr_colour] = wr_duty;
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (running) begin
            int cnt, col, slot;
            logic [NCH-1:0] exp_pwm;
            cnt  = (cyc / STEP) % 256;
            slot = cyc / SLOT;
            col  = slot % 3;
            for (int i = 0; i < NCH; i++) exp_pwm[i] = (cnt < m_act[i]);
            check(colour_en == 3'(1 << col), "R4 colour sequence", colour_en, 1 << col);
            check(pwm_out == exp_pwm, "R2 pwm compare", pwm_out, exp_pwm);
            if (slot < NSLOTS)
                for (int i = 0; i < NCH; i++) hist[slot][i] += int'(pwm_out[i]);
            if (cyc == 0) begin
                check(colour_en == 3'b001, "R1 reset colour", colour_en, 1);
                check(pwm_out == '0, "R1 reset outputs", pwm_out, 0);
            end
            if (cyc == 3*SLOT - 1)
                check(colour_en == 3'b100, "R5 blue before boundary", colour_en, 4);
            if (cyc == 3*SLOT) begin
                check(colour_en == 3'b001, "R5 red at boundary", colour_en, 1);
                check(pwm_out[0] == 1'b1, "R5 output rises with slot", pwm_out[0], 1);
            end
            if (cyc == 3*SLOT + 128*STEP - 1)
                check(pwm_out[2] == 1'b1, "R3 high before duty step", pwm_out[2], 1);
            if (cyc == 3*SLOT + 128*STEP)
                check(pwm_out[2] == 1'b0, "R3 low at duty step", pwm_out[2], 0);
            if (cyc == 3*SLOT + 256*STEP - 1)
                check(pwm_out[2] == 1'b0, "R3 low at period end", pwm_out[2], 0);
            if (cyc == 3*SLOT + 256*STEP)
                check(pwm_out[2] == 1'b1, "R3 high in second period", pwm_out[2], 1);
        end
    end

    task automatic wr(input int ch, input int col, input int val);
        @(negedge clk);
        wr_en = 1; wr_ch = CW'(ch); wr_colour = 2'(col); wr_duty = 8'(val);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        foreach (hist[s, i]) hist[s][i] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        running = 1;
        wr(0, 0, 255);
        wr(1, 0, 0);
        wr(2, 0, 128);
        wr(3, 0, 10);
        wr(0, 1, 64);
        wr(1, 2, 200);
        wr(0, 3, 77);   // invalid colour code
        wr(7, 0, 99);   // channel beyond NUM_CH
        wait (cyc == 3*SLOT + 500);
        wr(2, 0, 32);   // mid-slot write, due at slot 6
        wait (cyc == NSLOTS*SLOT - 1);
        @(negedge clk);
        running = 0;
        for (int i = 0; i < NCH; i++)
            check(hist[0][i] == 0, "R8 first red slot dark", hist[0][i], 0);
        check(hist[3][0] == 2040, "R7 full duty on-time", hist[3][0], 2040);
        check(hist[3][1] == 0, "R6 zero duty dark", hist[3][1], 0);
        check(hist[3][2] == 1024, "R8 mid-slot write ignored in slot", hist[3][2], 1024);
        check(hist[6][2] == 256, "R8 write used at next red slot", hist[6][2], 256);
        check(hist[3][3] == 80, "R10 small red duty", hist[3][3], 80);
        check(hist[1][0] == 512, "R10 green duty of ch0", hist[1][0], 512);
        check(hist[2][1] == 1600, "R10 blue duty of ch1", hist[2][1], 1600);
        check(hist[2][0] == 0, "R9 colour code 3 ignored", hist[2][0], 0);
        check(hist[5][0] == 0, "R9 blue of ch0 still zero", hist[5][0], 0);
        check(hist[4][4] == 0 && hist[6][5] == 0, "R9 unwritten channels dark",
              hist[4][4] + hist[6][5], 0);
        report();
    end

    initial begin
        #(5 * 40000);
        checks++;
        fails++;
        $display("FAIL watchdog expired at cycle %0d: actual 1 expected 0", cyc);
        report();
    end
endmodule